// File: doc/BRIEF.md
# Operating-Mode Sequencer with Reset Qualification

This block decides, cycle by cycle, which clocks of a small controller core run. Out of normal operation software can ask for a light sleep, in which only the instruction engine stops, or for a deep sleep, in which the oscillator itself is switched off. The block gates the CPU clock and the peripheral clock, enables the oscillator, and raises the core reset once the external reset pin has been held long enough.

Deep sleep ends either through reset or through an external interrupt line that is enabled and set to level sensing. Pulling such a line low restarts the oscillator. The core only resumes once the line is high again and the oscillator reports stable. The block also captures a test strap on the address-latch and program-strobe pins while reset is released. When the strap is present it raises a test flag, which makes the port pads float or pull weakly so that outside equipment can take over the board.

During either sleep the block tells the pad logic to park the two strobe pins. They park high when code runs from internal memory and low when it runs from external memory.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The core reset rises only after the reset pin has been sampled high on RST_MC*MC_DIV consecutive clock edges while the oscillator runs and is stable (24 with defaults). Any low sample restarts the count.
- R2: The core reset falls on the first clock edge that samples the reset pin low.
- R3: An idle request in normal operation stops the CPU clock and keeps the peripheral clock running from the next edge on. An enabled interrupt event (irq_evt) returns to normal operation on the next edge. An external line being low does not end idle.
- R4: A reset recognised during idle or deep sleep returns the block to normal operation (CPU clock running) on the same edge on which the core reset rises.
- R5: A deep-sleep request stops both clock gates and drops osc_en from the next edge on. It wins over a simultaneous idle request.
- R6: In deep sleep, irq_evt has no effect, and a low external line only counts when its ext_int_en bit and its ext_int_lvl bit (1 = level sensing) are both 1. ext_int_n bit i is line i, active low.
- R7: After an interrupt wake-up, osc_en is 1 and both clock gates stay off. Normal operation resumes on the first edge at which osc_stable is 1 and no enabled level-sensed line is low.
- R8: In deep sleep a high reset pin raises osc_en at once, without waiting for a clock edge. While osc_stable is 0 the reset count does not advance.
- R9: strobe_park is 1 in every sleep state outside test mode. strobe_lvl is 1 when ext_exec is 0 (internal code) and 0 when ext_exec is 1.
- R10: test_mode rises on the reset-release edge only if, on some edge while reset was recognised, ale_in was 0 and psen_in was 1, and ale_in is still 0 at release.
- R11: test_mode stays set until a newly recognised reset clears it. While it is set, osc_en stays 1 and strobe_park stays 0, even in deep sleep.
- R12: Idle and deep-sleep requests are ignored while the core reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| arst_n | input | 1 | Asynchronous power-up clear, active low |
| rst_pin | input | 1 | External reset pin level |
| idle_req | input | 1 | Software idle request, one-cycle pulse |
| pd_req | input | 1 | Software deep-sleep request, one-cycle pulse |
| irq_evt | input | 1 | An enabled interrupt is pending |
| ext_int_n | input | NINT | External interrupt line levels, active low |
| ext_int_en | input | NINT | Per-line interrupt enable |
| ext_int_lvl | input | NINT | Per-line sensing, 1 = level |
| osc_stable | input | 1 | Oscillator running and settled |
| ale_in | input | 1 | Sensed level of the address-latch pin |
| psen_in | input | 1 | Sensed level of the program-strobe pin |
| ext_exec | input | 1 | Core executes from external memory |
| cpu_clk_en | output | 1 | CPU clock gate |
| per_clk_en | output | 1 | Peripheral clock gate |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Qualified internal reset |
| test_mode | output | 1 | Strap-selected test mode, selects pad drive style |
| strobe_park | output | 1 | Park the strobe pins at strobe_lvl |
| strobe_lvl | output | 1 | Parking level for the strobe pins |

## Verification
The bench uses the defaults: a 12-clock machine cycle, a two-machine-cycle reset window and two external lines. With these values the 24-edge reset boundary can be hit exactly, one edge short and one edge past. With two lines, one can be set to level sensing and the other to edge sensing, so a low level on the edge-sensed line is shown to be ignored in deep sleep while the level-sensed one wakes the core. The short reset window also keeps the test-strap sequences (entry, failed entry and exit by reset) brief.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        M_RUN   = 2'd0,
        M_IDLE  = 2'd1,
        M_PDOWN = 2'd2,
        M_WAKE  = 2'd3
    } pmode_e;
endpackage

// File: rtl/pmc_rst_filter.sv
module pmc_rst_filter #(
    parameter int MC_DIV = 12,
    parameter int RST_MC = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_pin,
    input  logic run_en,
    output logic rst_next,
    output logic core_rst
);
    localparam int PW = (MC_DIV > 1) ? $clog2(MC_DIV) : 1;
    localparam int CW = $clog2(RST_MC + 1);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic [CW-1:0] mcnt;
        logic          hold;
    } flt_t;

    flt_t q, d;
    logic hit;

    always_comb begin
        d   = q;
        hit = run_en && rst_pin && (q.phase == PW'(MC_DIV - 1))
              && (q.mcnt == CW'(RST_MC - 1));
        if (!rst_pin) begin
            d.phase = '0;
            d.mcnt  = '0;
            d.hold  = 1'b0;
        end else if (run_en && !q.hold) begin
            if (q.phase == PW'(MC_DIV - 1)) begin
                d.phase = '0;
                d.mcnt  = q.mcnt + CW'(1);
            end else begin
                d.phase = q.phase + PW'(1);
            end
            if (hit) d.hold = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '0;
        else         q <= d;
    end

    assign rst_next = d.hold;
    assign core_rst = q.hold;

    p_rst_source_r1: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(core_rst) |-> $past(rst_pin));
    p_phase_range_r1: assert property (@(posedge clk) disable iff (!arst_n)
        int'(q.phase) < MC_DIV);
    p_release_r2: assert property (@(posedge clk) disable iff (!arst_n)
        (core_rst && !rst_pin) |=> !core_rst);
endmodule

// File: rtl/pmc_once_strap.sv
module pmc_once_strap (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_next,
    input  logic core_rst,
    input  logic ale_in,
    input  logic psen_in,
    output logic test_mode
);
    typedef struct packed {
        logic armed;
        logic once;
    } strap_t;

    strap_t q, d;
    logic   release_edge;

    always_comb begin
        d            = q;
        release_edge = core_rst && !rst_next;
        if (rst_next) begin
            if (!ale_in && psen_in) d.armed = 1'b1;
            else if (ale_in)        d.armed = 1'b0;
        end else begin
            d.armed = 1'b0;
        end
        if (rst_next && !core_rst) d.once = 1'b0;
        if (release_edge)          d.once = q.armed && !ale_in;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '0;
        else         q <= d;
    end

    assign test_mode = q.once;

    p_once_entry_r10: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(q.once) |-> $past(core_rst && !ale_in));
    p_once_sticky_r11: assert property (@(posedge clk) disable iff (!arst_n)
        (q.once && !core_rst) |=> (q.once || core_rst));
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
#(
    parameter int NINT = 2
) (
    input  logic            clk,
    input  logic            arst_n,
    input  logic            idle_req,
    input  logic            pd_req,
    input  logic            irq_evt,
    input  logic [NINT-1:0] ext_int_n,
    input  logic [NINT-1:0] ext_int_en,
    input  logic [NINT-1:0] ext_int_lvl,
    input  logic            osc_stable,
    input  logic            rst_pin,
    input  logic            rst_next,
    input  logic            core_rst,
    input  logic            once,
    input  logic            ext_exec,
    output logic            cpu_clk_en,
    output logic            per_clk_en,
    output logic            osc_en,
    output logic            strobe_park,
    output logic            strobe_lvl
);
    typedef struct packed {
        pmode_e mode;
    } fsm_t;

    fsm_t q, d;
    logic wake_pin;

    always_comb begin
        d        = q;
        wake_pin = |(ext_int_en & ext_int_lvl & ~ext_int_n);
        unique case (q.mode)
            M_RUN: begin
                if (!core_rst) begin
                    if (pd_req)        d.mode = M_PDOWN;
                    else if (idle_req) d.mode = M_IDLE;
                end
            end
            M_IDLE:  if (irq_evt)                 d.mode = M_RUN;
            M_PDOWN: if (wake_pin)                d.mode = M_WAKE;
            M_WAKE:  if (osc_stable && !wake_pin) d.mode = M_RUN;
            default: d.mode = M_RUN;
        endcase
        if (rst_next) d.mode = M_RUN;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '{mode: M_RUN};
        else         q <= d;
    end

    assign cpu_clk_en  = (q.mode == M_RUN);
    assign per_clk_en  = (q.mode == M_RUN) || (q.mode == M_IDLE);
    assign osc_en      = once || rst_pin || (q.mode != M_PDOWN);
    assign strobe_park = !once && (q.mode != M_RUN);
    assign strobe_lvl  = !ext_exec;

    p_idle_entry_r3: assert property (@(posedge clk) disable iff (!arst_n)
        (q.mode == M_RUN && !core_rst && !rst_next && idle_req && !pd_req)
        |=> (!cpu_clk_en && per_clk_en));
    p_rst_clears_r4: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(core_rst) |-> (q.mode == M_RUN));
    p_pd_prio_r5: assert property (@(posedge clk) disable iff (!arst_n)
        (q.mode == M_RUN && !core_rst && !rst_next && pd_req)
        |=> (q.mode == M_PDOWN));
    p_pd_hold_r6: assert property (@(posedge clk) disable iff (!arst_n)
        (q.mode == M_PDOWN && !wake_pin && !rst_next) |=> (q.mode == M_PDOWN));
    p_wake_wait_r7: assert property (@(posedge clk) disable iff (!arst_n)
        (q.mode == M_WAKE && !osc_stable && !rst_next) |=> (q.mode == M_WAKE));
    p_rst_ignores_req_r12: assert property (@(posedge clk) disable iff (!arst_n)
        (core_rst && rst_next) |=> (q.mode == M_RUN));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
    parameter int MC_DIV = 12,
    parameter int RST_MC = 2,
    parameter int NINT   = 2
) (
    input  logic            clk,
    input  logic            arst_n,
    input  logic            rst_pin,
    input  logic            idle_req,
    input  logic            pd_req,
    input  logic            irq_evt,
    input  logic [NINT-1:0] ext_int_n,
    input  logic [NINT-1:0] ext_int_en,
    input  logic [NINT-1:0] ext_int_lvl,
    input  logic            osc_stable,
    input  logic            ale_in,
    input  logic            psen_in,
    input  logic            ext_exec,
    output logic            cpu_clk_en,
    output logic            per_clk_en,
    output logic            osc_en,
    output logic            core_rst,
    output logic            test_mode,
    output logic            strobe_park,
    output logic            strobe_lvl
);
    logic rst_next;
    logic run_en;

    assign run_en = osc_en && osc_stable;

    pmc_rst_filter #(.MC_DIV(MC_DIV), .RST_MC(RST_MC)) u_filter (
        .clk      (clk),
        .arst_n   (arst_n),
        .rst_pin  (rst_pin),
        .run_en   (run_en),
        .rst_next (rst_next),
        .core_rst (core_rst)
    );

    pmc_once_strap u_strap (
        .clk       (clk),
        .arst_n    (arst_n),
        .rst_next  (rst_next),
        .core_rst  (core_rst),
        .ale_in    (ale_in),
        .psen_in   (psen_in),
        .test_mode (test_mode)
    );

    pmc_mode_fsm #(.NINT(NINT)) u_fsm (
        .clk         (clk),
        .arst_n      (arst_n),
        .idle_req    (idle_req),
        .pd_req      (pd_req),
        .irq_evt     (irq_evt),
        .ext_int_n   (ext_int_n),
        .ext_int_en  (ext_int_en),
        .ext_int_lvl (ext_int_lvl),
        .osc_stable  (osc_stable),
        .rst_pin     (rst_pin),
        .rst_next    (rst_next),
        .core_rst    (core_rst),
        .once        (test_mode),
        .ext_exec    (ext_exec),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .osc_en      (osc_en),
        .strobe_park (strobe_park),
        .strobe_lvl  (strobe_lvl)
    );

    p_osc_in_test_r11: assert property (@(posedge clk) disable iff (!arst_n)
        test_mode |-> (osc_en && !strobe_park));
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       rst_pin = 1'b0, idle_req = 1'b0, pd_req = 1'b0, irq_evt = 1'b0;
    logic [1:0] ext_int_n = 2'b11, ext_int_en = 2'b11, ext_int_lvl = 2'b01;
    logic       osc_stable = 1'b1, ale_in = 1'b1, psen_in = 1'b1, ext_exec = 1'b0;
    logic       cpu_clk_en, per_clk_en, osc_en, core_rst, test_mode, strobe_park, strobe_lvl;
    int         nchk = 0, nfail = 0;

    always #10 clk = ~clk;

    pwr_mode_ctrl dut (
        .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .idle_req(idle_req),
        .pd_req(pd_req), .irq_evt(irq_evt), .ext_int_n(ext_int_n),
        .ext_int_en(ext_int_en), .ext_int_lvl(ext_int_lvl), .osc_stable(osc_stable),
        .ale_in(ale_in), .psen_in(psen_in), .ext_exec(ext_exec),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .core_rst(core_rst), .test_mode(test_mode), .strobe_park(strobe_park),
        .strobe_lvl(strobe_lvl)
    );

    // row: {idle_req, pd_req, irq_evt, ext_int_n[1:0], cpu, per, osc, park}
    localparam int NV = 15;
    localparam logic [8:0] VEC [NV] = '{
        9'b1_0_0_11_0111,  // R3 enter idle
        9'b0_0_0_11_0111,  // R3 stay idle
        9'b0_0_1_11_1110,  // R3 irq ends idle
        9'b0_1_0_11_0001,  // R5 enter deep sleep
        9'b0_0_1_11_0001,  // R6 irq ignored
        9'b0_0_0_01_0001,  // R6 edge-sensed line ignored
        9'b0_0_0_10_0011,  // R7 level line wakes osc
        9'b0_0_0_10_0011,  // R7 held low: still waiting
        9'b0_0_0_11_1110,  // R7 line high: resume
        9'b1_1_0_11_0001,  // R5 deep sleep wins
        9'b0_0_0_10_0011,  // R7 wake
        9'b0_0_0_11_1110,  // R7 resume
        9'b1_0_0_11_0111,  // R3 idle
        9'b0_0_0_10_0111,  // R3 low line does not end idle
        9'b0_0_1_11_1110   // R3 irq ends idle
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(20 * 100000);
        nfail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #25 arst_n = 1'b1;
        tick();
        check("R2 reset state cpu", cpu_clk_en, 1);
        check("R2 reset state per", per_clk_en, 1);
        check("R8 reset state osc", osc_en, 1);
        check("R1 reset state core_rst", core_rst, 0);
        check("R10 reset state test", test_mode, 0);
        check("R9 reset state park", strobe_park, 0);

        for (int v = 0; v < NV; v++) begin
            {idle_req, pd_req, irq_evt, ext_int_n} = VEC[v][8:4];
            tick();
            check($sformatf("R3/R5/R6/R7 vec %0d", v),
                  {28'd0, cpu_clk_en, per_clk_en, osc_en, strobe_park},
                  {28'd0, VEC[v][3:0]});
        end
        {idle_req, pd_req, irq_evt, ext_int_n} = 5'b000_11;

        // R1 short pulse then exact window
        rst_pin = 1'b1; ticks(10);
        rst_pin = 1'b0; tick();
        rst_pin = 1'b1; ticks(23);
        check("R1 one edge short", core_rst, 0);
        tick();
        check("R1 window reached", core_rst, 1);
        // R12 requests during reset
        idle_req = 1'b1; pd_req = 1'b1; tick();
        idle_req = 1'b0; pd_req = 1'b0; tick();
        check("R12 requests ignored", cpu_clk_en, 1);
        rst_pin = 1'b0; tick();
        check("R2 release", core_rst, 0);
        check("R10 no strap", test_mode, 0);

        // R4 reset ends idle
        idle_req = 1'b1; tick(); idle_req = 1'b0;
        rst_pin = 1'b1; ticks(23);
        check("R4 still idle", cpu_clk_en, 0);
        tick();
        check("R4 core_rst", core_rst, 1);
        check("R4 cpu resumes", cpu_clk_en, 1);
        rst_pin = 1'b0; tick();

        // R8 reset exit from deep sleep
        pd_req = 1'b1; tick(); pd_req = 1'b0;
        check("R5 osc off", osc_en, 0);
        osc_stable = 1'b0; rst_pin = 1'b1; #1;
        check("R8 osc on at once", osc_en, 1);
        ticks(30);
        check("R8 count frozen", core_rst, 0);
        osc_stable = 1'b1; ticks(24);
        check("R8 reset recognised", core_rst, 1);
        check("R8 cpu runs", cpu_clk_en, 1);
        rst_pin = 1'b0; tick();

        // R7 wait for stable oscillator
        pd_req = 1'b1; tick(); pd_req = 1'b0;
        ext_int_n = 2'b10; tick();
        check("R7 wake osc", osc_en, 1);
        osc_stable = 1'b0; ext_int_n = 2'b11; tick();
        check("R7 waits for osc", cpu_clk_en, 0);
        check("R7 per gated", per_clk_en, 0);
        osc_stable = 1'b1; tick();
        check("R7 resumed", cpu_clk_en, 1);

        // R9 parking level
        ext_exec = 1'b1; idle_req = 1'b1; tick(); idle_req = 1'b0;
        check("R9 park", strobe_park, 1);
        check("R9 level external", strobe_lvl, 0);
        ext_exec = 1'b0; #1;
        check("R9 level internal", strobe_lvl, 1);
        irq_evt = 1'b1; tick(); irq_evt = 1'b0;
        check("R9 unpark", strobe_park, 0);

        // R10 strap entry
        ale_in = 1'b0; psen_in = 1'b1; rst_pin = 1'b1; ticks(24);
        check("R10 in reset", test_mode, 0);
        rst_pin = 1'b0; tick();
        check("R10 entered", test_mode, 1);
        // R11 behaviour in test mode
        pd_req = 1'b1; tick(); pd_req = 1'b0;
        check("R11 osc kept", osc_en, 1);
        check("R11 no park", strobe_park, 0);
        check("R11 sticky", test_mode, 1);
        ale_in = 1'b1; rst_pin = 1'b1; ticks(24);
        check("R11 cleared by reset", test_mode, 0);
        check("R11 run after reset", cpu_clk_en, 1);
        rst_pin = 1'b0; tick();
        check("R11 stays clear", test_mode, 0);

        // R10 negative: psen low
        ale_in = 1'b0; psen_in = 1'b0; rst_pin = 1'b1; ticks(24);
        rst_pin = 1'b0; tick();
        check("R10 psen low no entry", test_mode, 0);
        // R10 negative: ale high at release
        psen_in = 1'b1; rst_pin = 1'b1; ticks(24);
        ale_in = 1'b1; rst_pin = 1'b0; tick();
        check("R10 ale high at release", test_mode, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule